// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a byte-wide register file reached through a two-byte I/O window. The first byte of the window selects which register is addressed (the index); the second byte carries data to or from the selected register. The host side uses simple single-byte read and write strobes. Reads always return the register that the index currently selects, whichever window byte is read.

Writes through the data byte are filtered by index. Large index ranges are read-only. Two registers are pinned: each accepts only one exact byte value and keeps its contents for any other value. The remaining indices store the full byte. Only the upper part of the index space (0xE0 to 0xFF) holds storage. Every index below 0xE0 is read-only and reads as zero.

The window starts disabled after reset. A neighbouring bridge configuration space opens or closes it by writing a byte to its offset 0x85. While the window is closed, the block ignores every access and returns a fixed idle byte.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the window is closed and the index is 0x00. io_rdata is 0xFF and io_ack is low. Registers hold 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other index reads 0x00.
- R2: While the window is open, a write with io_addr=0 loads io_wdata into the index.
- R3: While the window is open, a read (io_sel and io_rd) at either io_addr value returns the selected register on io_rdata. io_ack is high for exactly the one cycle after the request edge.
- R4: Data writes (io_addr=1) are dropped when the index is in 0x00–0xDF, is 0xE4 or 0xE5, is in 0xE9–0xED, is 0xF3, 0xF5 or 0xF7, is in 0xF9–0xFB, or is in 0xFD–0xFF.
- R5: Index 0xE7 changes only on a write of 0xFE, and index 0xE8 only on a write of 0xBE. Any other value leaves the register as it was.
- R6: A data write to any other index in 0xE0–0xFF stores all 8 bits. These indices are 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R7: A control write (ctl_wr) to ctl_addr 0x85 sets the window open state to bit 1 of ctl_wdata. A control write to any other ctl_addr has no effect on the window.
- R8: While the window is closed, writes change neither the index nor any register. A read in that state gives io_rdata=0xFF in the following cycle, and io_ack stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Bridge configuration byte write strobe |
| ctl_addr | input | 8 | Bridge configuration byte offset |
| ctl_wdata | input | 8 | Bridge configuration write byte |
| io_sel | input | 1 | Access targets this two-byte window |
| io_addr | input | 1 | Window byte: 0 selects the index, 1 selects data |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, registered |
| io_ack | output | 1 | Read acknowledge, one-cycle pulse |

## Verification
A corrupted index shows up on the very next read: the value returned belongs to a different register. A stuck or mis-decoded open flag is just as quick to see. In the cycle after a read, the acknowledge either goes missing or appears when it should not, and the idle byte 0xFF replaces real data or vice versa. A wrong write filter stays hidden until the affected index is read back. For that reason the bench reads each filtered index right after writing to it. The pinned registers at 0xE7 and 0xE8 must also read their reset bytes after any rejected value.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int DATA_W      = 8;
    localparam int IDX_W       = 8;
    localparam int BANK_BASE   = 224;
    localparam int BANK_N      = 256 - BANK_BASE;
    localparam logic [7:0] OPEN_CTL_OFS = 8'h85;
    localparam int OPEN_CTL_BIT = 1;
    localparam logic [DATA_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        WR_OPEN   = 2'd0,
        WR_LOCKED = 2'd1,
        WR_MATCH  = 2'd2
    } wr_rule_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              open;
        logic [DATA_W-1:0] rdata;
        logic              ack;
    } port_state_t;

    function automatic wr_rule_e rule_of(input logic [IDX_W-1:0] i);
        if (i inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3,
                      8'hF5, 8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]})
            return WR_LOCKED;
        if (i == 8'hE7 || i == 8'hE8)
            return WR_MATCH;
        return WR_OPEN;
    endfunction

    function automatic logic [DATA_W-1:0] pinned_value(input logic [IDX_W-1:0] i);
        case (i)
            8'hE7:   return 8'hFE;
            8'hE8:   return 8'hBE;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] init_value(input logic [IDX_W-1:0] i);
        case (i)
            8'hE0:   return 8'h3C;
            8'hE2:   return 8'h03;
            8'hE3:   return 8'hFC;
            8'hE6:   return 8'hDE;
            8'hE7:   return 8'hFE;
            8'hE8:   return 8'hBE;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_wr_filter.sv
module cfg_wr_filter
    import cfg_port_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output logic              accept
);
    wr_rule_e rule;

    always_comb begin
        rule = rule_of(idx);
        case (rule)
            WR_LOCKED: accept = 1'b0;
            WR_MATCH:  accept = (data == pinned_value(idx));
            default:   accept = 1'b1;
        endcase
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_port_pkg::*;
#(
    parameter int BASE = BANK_BASE,
    parameter int N    = BANK_N
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             widx,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [IDX_W-1:0]             ridx,
    output logic [DATA_W-1:0]            rdata,
    output logic [N-1:0][DATA_W-1:0]     regs
);
    localparam int OFF_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(BASE);

    logic [N-1:0][DATA_W-1:0] bank_d, bank_q;
    logic [IDX_W-1:0] woff, roff;

    assign woff = widx - BASE_IDX;
    assign roff = ridx - BASE_IDX;

    always_comb begin
        bank_d = bank_q;
        if (we && widx >= BASE_IDX)
            bank_d[woff[OFF_W-1:0]] = wdata;
    end

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) bank_q[g] <= init_value(IDX_W'(BASE + g));
            else        bank_q[g] <= bank_d[g];
        end
    end

    always_comb begin
        if (ridx >= BASE_IDX) rdata = bank_q[roff[OFF_W-1:0]];
        else                  rdata = '0;
    end

    assign regs = bank_q;
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_addr,
    input  logic [7:0]        ctl_wdata,
    input  logic              io_sel,
    input  logic              io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_ack
);
    port_state_t st_d, st_q;
    logic        wr_ok;
    logic        bank_we;
    logic [DATA_W-1:0] bank_rdata;
    logic [BANK_N-1:0][DATA_W-1:0] bank_regs;

    cfg_wr_filter u_filter (
        .idx    (st_q.idx),
        .data   (io_wdata),
        .accept (wr_ok)
    );

    cfg_reg_bank #(.BASE(BANK_BASE), .N(BANK_N)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (st_q.idx),
        .wdata (io_wdata),
        .ridx  (st_q.idx),
        .rdata (bank_rdata),
        .regs  (bank_regs)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        bank_we  = io_sel && st_q.open && io_wr && io_addr && wr_ok;

        if (ctl_wr && ctl_addr == OPEN_CTL_OFS)
            st_d.open = ctl_wdata[OPEN_CTL_BIT];

        if (io_sel && st_q.open && io_wr && !io_addr)
            st_d.idx = io_wdata;

        if (io_sel && io_rd) begin
            if (st_q.open) begin
                st_d.rdata = bank_rdata;
                st_d.ack   = 1'b1;
            end else begin
                st_d.rdata = IDLE_BYTE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx   <= '0;
            st_q.open  <= 1'b0;
            st_q.rdata <= IDLE_BYTE;
            st_q.ack   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata = st_q.rdata;
    assign io_ack   = st_q.ack;
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk
    import cfg_port_pkg::*;
#(
    parameter int N = BANK_N
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ctl_wr,
    input logic [7:0]               ctl_addr,
    input logic [7:0]               ctl_wdata,
    input logic                     io_sel,
    input logic                     io_addr,
    input logic                     io_wr,
    input logic                     io_rd,
    input logic [7:0]               io_wdata,
    input logic [7:0]               io_rdata,
    input logic                     io_ack,
    input logic                     open,
    input logic [7:0]               idx,
    input logic [N-1:0][7:0]        regs
);
    p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_wr && !io_addr && open) |=> (idx == $past(io_wdata)));

    p_ack_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> $past(io_sel && io_rd && open));

    p_low_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_wr && io_addr && open && idx < 8'hE0) |=> $stable(regs));

    p_e7_pinned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        regs[7] == 8'hFE);

    p_e8_pinned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        regs[8] == 8'hBE);

    p_open_ctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_addr == 8'h85) |=> (open == $past(ctl_wdata[1])));

    p_closed_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_rd && !open) |=> (io_rdata == 8'hFF && !io_ack));

    p_closed_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_wr && !open) |=> ($stable(idx) && $stable(regs)));
endmodule

bind cfg_index_port cfg_index_port_chk #(.N(cfg_port_pkg::BANK_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_addr  (ctl_addr),
    .ctl_wdata (ctl_wdata),
    .io_sel    (io_sel),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_ack    (io_ack),
    .open      (st_q.open),
    .idx       (st_q.idx),
    .regs      (bank_regs)
);

// File: tb/cfg_index_port_test.sv
module cfg_index_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_addr = '0;
    logic [7:0] ctl_wdata = '0;
    logic       io_sel = 1'b0;
    logic       io_addr = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       io_ack;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    cfg_index_port uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .io_sel(io_sel), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected byte per acknowledge
    always @(negedge clk) begin
        if (rst_n && io_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected ack", 1, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(io_rdata == e, t, io_rdata, e);
            end
        end
    end

    task automatic ctl_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic io_write(input logic a, input logic [7:0] d);
        @(posedge clk); #1;
        io_sel = 1'b1; io_addr = a; io_wr = 1'b1; io_wdata = d;
        @(posedge clk); #1;
        io_sel = 1'b0; io_wr = 1'b0;
    endtask

    task automatic io_read(input logic a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        io_sel = 1'b1; io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        io_sel = 1'b0; io_rd = 1'b0;
    endtask

    task automatic read_idx(input logic [7:0] i, input logic [7:0] e, input string t);
        io_write(1'b0, i);
        io_read(1'b1, e, t);
    endtask

    task automatic closed_read(input string t);
        @(posedge clk); #1;
        io_sel = 1'b1; io_addr = 1'b1; io_rd = 1'b1;
        @(posedge clk); #1;
        io_sel = 1'b0; io_rd = 1'b0;
        @(negedge clk);
        check(io_rdata == 8'hFF, t, io_rdata, 8'hFF);
        check(io_ack == 1'b0, t, io_ack, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(io_rdata == 8'hFF, "R1 rdata after reset", io_rdata, 8'hFF);
        check(io_ack == 1'b0, "R1 ack after reset", io_ack, 0);
        // R1 / R8: window closed after reset
        closed_read("R1 R8 closed after reset");

        // R7: open via offset 0x85 bit 1
        ctl_write(8'h85, 8'h02);
        // R1: reset values, R2 index load, R3 readback
        read_idx(8'hE0, 8'h3C, "R1 reset E0");
        read_idx(8'hE1, 8'h00, "R1 reset E1");
        read_idx(8'hE2, 8'h03, "R1 reset E2");
        read_idx(8'hE3, 8'hFC, "R1 reset E3");
        read_idx(8'hE6, 8'hDE, "R1 reset E6");
        read_idx(8'hE7, 8'hFE, "R1 reset E7");
        read_idx(8'hE8, 8'hBE, "R1 reset E8");
        read_idx(8'h10, 8'h00, "R1 reset low index");
        // R3: read through index byte also returns selected register
        io_write(1'b0, 8'hE6);
        io_read(1'b0, 8'hDE, "R3 read via index byte");

        // R6: full-byte stores
        io_write(1'b0, 8'hE0); io_write(1'b1, 8'hA5);
        io_read(1'b1, 8'hA5, "R6 store E0");
        io_write(1'b0, 8'hF0); io_write(1'b1, 8'h5A);
        io_read(1'b1, 8'h5A, "R6 store F0");
        io_write(1'b0, 8'hFC); io_write(1'b1, 8'hFF);
        io_read(1'b1, 8'hFF, "R6 store FC");
        io_write(1'b0, 8'hF8); io_write(1'b1, 8'h81);
        io_read(1'b1, 8'h81, "R6 store F8");

        // R4: read-only indices drop writes
        io_write(1'b0, 8'h20); io_write(1'b1, 8'h77);
        io_read(1'b1, 8'h00, "R4 drop 20");
        io_write(1'b0, 8'hE4); io_write(1'b1, 8'h11);
        io_read(1'b1, 8'h00, "R4 drop E4");
        io_write(1'b0, 8'hEB); io_write(1'b1, 8'h22);
        io_read(1'b1, 8'h00, "R4 drop EB");
        io_write(1'b0, 8'hF3); io_write(1'b1, 8'h33);
        io_read(1'b1, 8'h00, "R4 drop F3");
        io_write(1'b0, 8'hFF); io_write(1'b1, 8'h44);
        io_read(1'b1, 8'h00, "R4 drop FF");

        // R5: pinned registers
        io_write(1'b0, 8'hE7); io_write(1'b1, 8'h12);
        io_read(1'b1, 8'hFE, "R5 E7 reject");
        io_write(1'b1, 8'hFE);
        io_read(1'b1, 8'hFE, "R5 E7 accept");
        io_write(1'b0, 8'hE8); io_write(1'b1, 8'h00);
        io_read(1'b1, 8'hBE, "R5 E8 reject");

        // R7: other offsets have no effect
        io_write(1'b0, 8'hF0);
        ctl_write(8'h84, 8'h00);
        ctl_write(8'h05, 8'h00);
        io_read(1'b1, 8'h5A, "R7 other offset ignored");
        // R7: close with bit 1 clear
        ctl_write(8'h85, 8'hFD);
        closed_read("R7 closed by bit1=0");

        // R8: writes ignored while closed
        io_write(1'b0, 8'hE1);
        io_write(1'b1, 8'h33);
        ctl_write(8'h85, 8'h02);
        io_read(1'b1, 8'h5A, "R8 index kept");
        read_idx(8'hE1, 8'h00, "R8 data dropped");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R3 all reads acknowledged", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule